// File: doc/BRIEF.md
# Byte-Serial Counter Host Register Interface

This block is the host-facing register file that sits between an 8-bit processor bus and a 24-bit counter core. The host selects the block with an active-low chip select and uses separate active-low read and write strobes. A control/data select line steers each access. With the select high, writes go to one of four control registers, picked by the two top data bits, and reads return a status byte. With the select low, writes fill a three-byte preset register and reads drain a three-byte output latch. A single byte pointer is shared by preset writes and latch reads. It advances after each data access and wraps back to byte 0.

A write to the master control register issues one-shot commands from a bit-mapped word, and several commands may be combined in one write. One bit resets the pointer and another captures the live counter value into the latch. Three bits emit single-cycle pulses that tell the counter core to clear, to load from the preset, or to clear its compare toggle. The last bit is a master reset. Combined bits take effect in ascending bit order within one clock cycle. All strobes are brought into the system clock domain, and each access acts exactly once, on the clock where its synchronised strobe becomes active.

Top module: `cntr_host_regs`

## Requirements
- R1: After the synchronous reset, `preset` is all ones, `icr_q`, `occr_q` and `qr_q` are zero, all command pulses are low, and the output latch holds zero.
- R2: A control write (cd=1) routes by data bits 7:6: 00 is the master command, 01 loads `icr_q` from bits 5:0, 10 loads `occr_q` from bits 5:0, and 11 loads `qr_q` from bits 1:0. The other control registers keep their values.
- R3: Data writes (cd=0) fill preset byte 0 (`preset[7:0]`), then byte 1, then byte 2. A fourth write wraps the pointer and lands in byte 0 again.
- R4: Data reads (cd=0) return latch byte 0 (counter bits 7:0), then byte 1, then byte 2, and then wrap to byte 0. They use the same pointer as preset writes.
- R5: A control read (cd=1) returns `stat_in` on bits 4:0 and zero on bits 7:5.
- R6: Master command bit 0 sets the byte pointer back to byte 0.
- R7: Master command bit 1 copies `cnt_in` into the output latch.
- R8: Master command bits 2, 3 and 4 each raise `cmd_clr`, `cmd_load` or `cmd_cmp_clr` for exactly one clock per write. No follow-up write of zero is needed.
- R9: Master command bit 5 zeroes all control registers, the latch and the pointer, sets the preset to all ones, and pulses `cmd_mrst` for one clock.
- R10: Bits combined in one master write act in ascending order. A latch capture together with master reset leaves the latch at zero. A pointer reset together with a capture leaves fresh data at byte 0.
- R11: `dout_oe` is high exactly while `cs_n` and `rd_n` are both low. Strobes given while `cs_n` is high change no register.
- R12: A strobe held active for many clocks performs its action only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | Control/data select: 1 control and status, 0 preset and latch |
| din | input | 8 | Bus write data |
| dout | output | 8 | Registered bus read data |
| dout_oe | output | 1 | Bus drive enable for the pad |
| cnt_in | input | 24 | Live counter value from the counter core |
| stat_in | input | 5 | Status bits from the counter core |
| preset | output | 24 | Preset register contents |
| icr_q | output | 6 | Input control register |
| occr_q | output | 6 | Output/counter control register |
| qr_q | output | 2 | Quadrature control register |
| cmd_clr | output | 1 | One-clock counter clear command |
| cmd_load | output | 1 | One-clock load-from-preset command |
| cmd_cmp_clr | output | 1 | One-clock compare toggle clear command |
| cmd_mrst | output | 1 | One-clock master reset command |

## Verification
If the shared pointer is off, it shows up on the next data access: a preset byte lands in the wrong lane of `preset`, or a read returns the wrong latch byte. So the bench writes and reads full three-byte sequences and continues past the wrap. A wrongly decoded control target changes a neighbouring register output within three clocks of the strobe. A broken edge detector shows up as repeated command pulses during a held strobe, which the bench counts directly. The combined-command order can only be seen in the latch contents, so the bench reads the latch back after every combined master write.

// File: rtl/cntr_host_pkg.sv
package cntr_host_pkg;
  typedef enum logic [1:0] {
    TGT_MASTER = 2'b00,
    TGT_INPUT  = 2'b01,
    TGT_OUTPUT = 2'b10,
    TGT_QUAD   = 2'b11
  } ctl_tgt_e;

  // master command bit positions, applied in ascending order
  localparam int MB_PTR_RST = 0;
  localparam int MB_LATCH   = 1;
  localparam int MB_CLEAR   = 2;
  localparam int MB_LOAD    = 3;
  localparam int MB_CMP_CLR = 4;
  localparam int MB_MRST    = 5;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_raw,
  output logic fire
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], act_raw};
  end

  assign fire = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R12: one action per strobe assertion
  a_r12_single_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/byte_ptr.sv
module byte_ptr #(
  parameter int NBYTES = 3,
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R3: pointer never leaves the byte range
  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < NBYTES);
  // R6: pointer moves only on an access or a reset command
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/cntr_host_regs.sv
module cntr_host_regs
  import cntr_host_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NBYTES      = 3,
  parameter int ICR_W       = 6,
  parameter int OCCR_W      = 6,
  parameter int QR_W        = 2,
  parameter int ST_W        = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CW = DW * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cd,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  input  logic [CW-1:0]     cnt_in,
  input  logic [ST_W-1:0]   stat_in,
  output logic [CW-1:0]     preset,
  output logic [ICR_W-1:0]  icr_q,
  output logic [OCCR_W-1:0] occr_q,
  output logic [QR_W-1:0]   qr_q,
  output logic              cmd_clr,
  output logic              cmd_load,
  output logic              cmd_cmp_clr,
  output logic              cmd_mrst
);
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic wr_fire, rd_fire;
  logic ctl_wr, data_wr, ctl_rd, data_rd, mcr_wr, do_mrst;
  ctl_tgt_e tgt;
  logic [PW-1:0] ptr;
  logic [NBYTES-1:0][DW-1:0] preset_q;
  logic [NBYTES-1:0][DW-1:0] latch_q;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .act_raw(~cs_n & ~wr_n), .fire(wr_fire));
  strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .act_raw(~cs_n & ~rd_n), .fire(rd_fire));

  assign ctl_wr  = wr_fire &  cd;
  assign data_wr = wr_fire & ~cd;
  assign ctl_rd  = rd_fire &  cd;
  assign data_rd = rd_fire & ~cd;
  assign tgt     = ctl_tgt_e'(din[DW-1:DW-2]);
  assign mcr_wr  = ctl_wr && (tgt == TGT_MASTER);
  assign do_mrst = mcr_wr & din[MB_MRST];

  byte_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk(clk), .rst(rst),
    .clr((mcr_wr & din[MB_PTR_RST]) | do_mrst),
    .adv(data_wr | data_rd),
    .ptr(ptr));

  // control registers
  always_ff @(posedge clk) begin
    if (rst || do_mrst) begin
      icr_q  <= '0;
      occr_q <= '0;
      qr_q   <= '0;
    end else if (ctl_wr) begin
      case (tgt)
        TGT_INPUT:  icr_q  <= din[ICR_W-1:0];
        TGT_OUTPUT: occr_q <= din[OCCR_W-1:0];
        TGT_QUAD:   qr_q   <= din[QR_W-1:0];
        default: ;
      endcase
    end
  end

  // preset and latch byte lanes
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || do_mrst)                 preset_q[b] <= '1;
      else if (data_wr && ptr == PW'(b))  preset_q[b] <= din;
    end
    always_ff @(posedge clk) begin
      if (rst || do_mrst)                 latch_q[b] <= '0;
      else if (mcr_wr && din[MB_LATCH])   latch_q[b] <= cnt_in[b*DW +: DW];
    end
  end
  assign preset = preset_q;

  // registered read data
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (ctl_rd)  dout <= DW'(stat_in);
    else if (data_rd) dout <= latch_q[ptr];
  end
  assign dout_oe = ~cs_n & ~rd_n;

  // one-shot command pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_clr     <= 1'b0;
      cmd_load    <= 1'b0;
      cmd_cmp_clr <= 1'b0;
      cmd_mrst    <= 1'b0;
    end else begin
      cmd_clr     <= mcr_wr & din[MB_CLEAR];
      cmd_load    <= mcr_wr & din[MB_LOAD];
      cmd_cmp_clr <= mcr_wr & din[MB_CMP_CLR];
      cmd_mrst    <= do_mrst;
    end
  end

  // R9: master reset pulse coincides with default register contents
  a_r9_mrst_preset: assert property (@(posedge clk) disable iff (rst)
    cmd_mrst |-> (preset == '1));
  a_r9_mrst_ctrl: assert property (@(posedge clk) disable iff (rst)
    cmd_mrst |-> (icr_q == '0 && occr_q == '0 && qr_q == '0));
  // R2: control register changes only after a control write
  a_r2_icr_on_write: assert property (@(posedge clk) disable iff (rst)
    (icr_q != $past(icr_q)) |-> $past(ctl_wr));
  // R8: command pulses last one clock
  a_r8_clr_single: assert property (@(posedge clk) disable iff (rst)
    cmd_clr |=> !cmd_clr);
  a_r8_load_single: assert property (@(posedge clk) disable iff (rst)
    cmd_load |=> !cmd_load);
endmodule

// File: tb/cntr_host_regs_tb_top.sv
module cntr_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe;
  logic [23:0] cnt_in = 24'hA1B2C3;
  logic [4:0]  stat_in = 5'h15;
  logic [23:0] preset;
  logic [5:0]  icr_q, occr_q;
  logic [1:0]  qr_q;
  logic cmd_clr, cmd_load, cmd_cmp_clr, cmd_mrst;

  int n_chk = 0, n_bad = 0;
  int n_clr = 0, n_load = 0, n_cmp = 0, n_mrst = 0;

  always #5 clk = ~clk;

  cntr_host_regs dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(din), .dout(dout), .dout_oe(dout_oe), .cnt_in(cnt_in),
    .stat_in(stat_in), .preset(preset), .icr_q(icr_q), .occr_q(occr_q),
    .qr_q(qr_q), .cmd_clr(cmd_clr), .cmd_load(cmd_load),
    .cmd_cmp_clr(cmd_cmp_clr), .cmd_mrst(cmd_mrst));

  always @(negedge clk) begin
    if (cmd_clr)     n_clr++;
    if (cmd_load)    n_load++;
    if (cmd_cmp_clr) n_cmp++;
    if (cmd_mrst)    n_mrst++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [7:0] d, input int hold = 6);
    @(negedge clk);
    cs_n = 1'b0; cd = c; din = d; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_rd(input logic c, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; cd = c; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    d = dout; oe = dout_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    chk("R1 preset", preset, 24'hFFFFFF);
    chk("R1 ctrl", {icr_q, occr_q, qr_q}, 0);
    chk("R1 pulses", {cmd_clr, cmd_load, cmd_cmp_clr, cmd_mrst}, 0);
    chk("R11 oe idle", dout_oe, 0);
    bus_rd(1'b0, d, oe);
    chk("R1 latch zero", d, 8'h00);
    chk("R11 oe during read", oe, 1);
    bus_wr(1'b1, 8'h01);
  endtask

  task automatic t_ctrl();
    bus_wr(1'b1, 8'h6A);
    chk("R2 icr", icr_q, 6'h2A);
    chk("R2 occr untouched", occr_q, 0);
    bus_wr(1'b1, 8'h95);
    chk("R2 occr", occr_q, 6'h15);
    bus_wr(1'b1, 8'hFE);
    chk("R2 qr", qr_q, 2'b10);
    chk("R2 icr kept", icr_q, 6'h2A);
  endtask

  task automatic t_preset();
    bus_wr(1'b1, 8'h01);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b0, 8'h22);
    bus_wr(1'b0, 8'h33);
    chk("R3 three bytes", preset, 24'h332211);
    bus_wr(1'b0, 8'h44);
    chk("R3 wrap", preset, 24'h332244);
  endtask

  task automatic t_latch();
    logic [7:0] d; logic oe;
    cnt_in = 24'hA1B2C3;
    bus_wr(1'b1, 8'h03);
    bus_rd(1'b0, d, oe); chk("R4 byte0 R7", d, 8'hC3);
    bus_rd(1'b0, d, oe); chk("R4 byte1", d, 8'hB2);
    bus_rd(1'b0, d, oe); chk("R4 byte2", d, 8'hA1);
    bus_rd(1'b0, d, oe); chk("R4 wrap", d, 8'hC3);
    cnt_in = 24'h0F0E0D;
    bus_wr(1'b1, 8'h03);
    bus_rd(1'b0, d, oe); chk("R10 ptr reset with capture", d, 8'h0D);
  endtask

  task automatic t_ptr();
    logic [7:0] d; logic oe;
    bus_wr(1'b0, 8'h55);
    bus_wr(1'b1, 8'h01);
    bus_rd(1'b0, d, oe); chk("R6 pointer reset", d, 8'h0D);
  endtask

  task automatic t_status();
    logic [7:0] d; logic oe;
    stat_in = 5'h15;
    bus_rd(1'b1, d, oe); chk("R5 status", d, 8'h15);
    stat_in = 5'h1F;
    bus_rd(1'b1, d, oe); chk("R5 upper zero", d, 8'h1F);
  endtask

  task automatic t_pulses();
    int c0 = n_clr, l0 = n_load, p0 = n_cmp;
    bus_wr(1'b1, 8'h1C);
    chk("R8 clr", n_clr - c0, 1);
    chk("R8 load", n_load - l0, 1);
    chk("R8 cmp clr", n_cmp - p0, 1);
    bus_wr(1'b1, 8'h04, 30);
    chk("R12 held strobe", n_clr - c0, 2);
  endtask

  task automatic t_mrst();
    logic [7:0] d; logic oe;
    int m0 = n_mrst;
    bus_wr(1'b1, 8'h7F);
    bus_wr(1'b1, 8'hBF);
    bus_wr(1'b1, 8'hC3);
    bus_wr(1'b0, 8'h99);
    bus_wr(1'b1, 8'h20);
    chk("R9 ctrl cleared", {icr_q, occr_q, qr_q}, 0);
    chk("R9 preset ones", preset, 24'hFFFFFF);
    chk("R9 pulse", n_mrst - m0, 1);
    bus_rd(1'b0, d, oe); chk("R9 latch zero", d, 8'h00);
    cnt_in = 24'h123456;
    bus_wr(1'b1, 8'h22);
    bus_rd(1'b1, d, oe);
    bus_wr(1'b1, 8'h01);
    bus_rd(1'b0, d, oe); chk("R10 capture then reset", d, 8'h00);
  endtask

  task automatic t_cs();
    bus_wr(1'b1, 8'h6A);
    @(negedge clk);
    cd = 1'b1; din = 8'h55; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 cs high ignored", icr_q, 6'h2A);
    rd_n = 1'b0;
    @(negedge clk);
    chk("R11 oe needs cs", dout_oe, 0);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_preset();
    t_latch();
    t_ptr();
    t_status();
    t_pulses();
    t_mrst();
    t_cs();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule